// File: doc/BRIEF.md
# Tiered Slave Arbiter (Fixed Priority over Weighted Round-Robin)

This block decides which of several bus masters owns one slave port of a multi-master crossbar. Masters fall into two tiers. Indices below `N_FIXED` form a strict-priority tier, and any requester in that tier wins over the rest. The remaining masters share the slave in weighted round-robin order. When a round-robin master is granted, it is given a budget of transfers equal to its programmed weight. Once that budget is spent, the arbiter chooses again, even if the master's burst has not finished. This groups back-to-back accesses from one master, which helps slaves that pay a penalty each time the owner changes.

The grant is held in a register and moves only at an arbitration point: a cycle with `ready_i` high in which the owner either completes a transfer or has stopped requesting. A master that holds its lock input keeps the grant for as long as the lock stays high. The lock overrides both the budget and the priority of other masters. When no master requests, the grant stays parked on the last owner. Address decode, data steering and slave wait-state generation belong to neighbouring blocks.

Top module: `tiered_slave_arb`

## Requirements
- R1: After reset the grant is parked on master 0 (`gnt_o` = 1, `gnt_idx_o` = 0). At all times `gnt_o` is one-hot with its set bit at position `gnt_idx_o`.
- R2: Suppose a master with index below `N_FIXED` requests while the owner completes a transfer or has stopped requesting, with `ready_i` high and the owner not locked. Then a fixed-tier master holds the grant in the next cycle.
- R3: Among requesting fixed-tier masters, the lowest index is granted.
- R4: A round-robin master, once granted, keeps the slave for exactly its weight in completed transfers while it keeps requesting and no fixed-tier master requests. It is then re-arbitrated, even when its burst is longer. The weight of master k is read from `weight_i[k*WGT_W +: WGT_W]`.
- R5: A weight of zero gives a budget of one transfer.
- R6: The round-robin search starts at the index after the last round-robin master granted and wraps around. Two continuously requesting round-robin masters therefore alternate in groups of their weights.
- R7: While the owner holds its `lock_i` bit high, the grant does not change, whatever its budget and whatever other masters request.
- R8: If the owner drops its request, the grant moves to another requester at the next cycle with `ready_i` high.
- R9: With no requests the grant stays on the last owner.
- R10: A change of the weight inputs does not alter the budget of a grant in progress. It takes effect at that master's next grant.
- R11: While `ready_i` is low the grant does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_i | input | 1 | Slave ready; arbitration points occur only while high |
| req_i | input | N_MST | Request per master |
| lock_i | input | N_MST | Locked-sequence flag per master |
| xfer_i | input | N_MST | Per-master strobe: address phase accepted this cycle |
| weight_i | input | N_MST*WGT_W | Packed per-master transfer budgets (fixed-tier fields unused) |
| gnt_o | output | N_MST | One-hot grant |
| gnt_idx_o | output | $clog2(N_MST) | Index of the granted master |

## Verification
The bench builds the arbiter with five masters, two of them in the fixed tier, and 3-bit weights. That makes an exhaustive sweep over all 64 weight pairs of two round-robin masters practical, zero included. Each sweep is compared cycle by cycle against a group pattern computed from the weights. The small tier sizes also let directed sequences reach the remaining interactions in a few cycles each: lock against budget, pre-emption, priority order, wrap-around of the rotation, stalls on ready, parking and weight updates during a grant.

// File: rtl/tarb_pkg.sv
package tarb_pkg;

   // Budget actually granted for a programmed weight: zero counts as one.
   function automatic logic [31:0] eff_budget(input logic [31:0] w);
      return (w == 32'd0) ? 32'd1 : w;
   endfunction

   // Mask with the lowest n bits set, for up to 64 masters.
   function automatic logic [63:0] low_mask(input int n);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < 64; i++) begin
         if (i < n) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/tarb_fixed_pick.sv
module tarb_fixed_pick #(
   parameter int N_MST   = 10,
   parameter int N_FIXED = 3,
   localparam int IDX_W  = $clog2(N_MST)
) (
   input  logic [N_MST-1:0] req_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   if (N_FIXED > N_MST) begin : g_bad_cfg
      $error("tarb_fixed_pick: N_FIXED larger than N_MST");
   end

   if (N_FIXED == 0) begin : g_no_tier
      assign found_o = 1'b0;
      assign idx_o   = '0;
   end else begin : g_tier
      always_comb begin
         found_o = 1'b0;
         idx_o   = '0;
         // Scan downward so the lowest requesting index is the last written.
         for (int i = N_FIXED - 1; i >= 0; i--) begin
            if (req_i[i]) begin
               found_o = 1'b1;
               idx_o   = IDX_W'(i);
            end
         end
      end
   end

endmodule

// File: rtl/tarb_rr_pick.sv
module tarb_rr_pick #(
   parameter int N_MST   = 10,
   parameter int N_FIXED = 3,
   localparam int IDX_W  = $clog2(N_MST)
) (
   input  logic [N_MST-1:0] req_i,
   input  logic [IDX_W-1:0] last_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   if (N_FIXED >= N_MST) begin : g_bad_cfg
      $error("tarb_rr_pick: no round-robin masters left");
   end

   always_comb begin
      found_o = 1'b0;
      idx_o   = last_i;
      // Start one past the last winner, wrap, end on the last winner itself.
      for (int k = 1; k <= N_MST; k++) begin
         int j;
         j = int'(last_i) + k;
         if (j >= N_MST) j = j - N_MST;
         if (!found_o && j >= N_FIXED && req_i[j]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(j);
         end
      end
   end

endmodule

// File: rtl/tarb_budget.sv
module tarb_budget
   import tarb_pkg::*;
#(
   parameter int WGT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WGT_W-1:0] weight_i,
   input  logic             beat_i,
   output logic             last_o
);

   if (WGT_W < 1 || WGT_W > 16) begin : g_bad_cfg
      $error("tarb_budget: WGT_W out of range");
   end

   logic [WGT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= WGT_W'(1);
      end else if (load_i) begin
         cnt_q <= WGT_W'(eff_budget(32'(weight_i)));
      end else if (beat_i && cnt_q > WGT_W'(1)) begin
         // Saturates at one so a locked owner cannot underflow the budget.
         cnt_q <= cnt_q - WGT_W'(1);
      end
   end

   assign last_o = (cnt_q == WGT_W'(1));

   AST_BUDGET_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q != '0); // R5

   AST_BUDGET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && weight_i > WGT_W'(1)) |=> !last_o); // R4

endmodule

// File: rtl/tiered_slave_arb.sv
module tiered_slave_arb
   import tarb_pkg::*;
#(
   parameter int N_MST   = 10,
   parameter int N_FIXED = 3,
   parameter int WGT_W   = 4,
   localparam int IDX_W  = $clog2(N_MST)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ready_i,
   input  logic [N_MST-1:0]       req_i,
   input  logic [N_MST-1:0]       lock_i,
   input  logic [N_MST-1:0]       xfer_i,
   input  logic [N_MST*WGT_W-1:0] weight_i,
   output logic [N_MST-1:0]       gnt_o,
   output logic [IDX_W-1:0]       gnt_idx_o
);

   if (N_MST < 2 || N_MST > 64) begin : g_bad_mst
      $error("tiered_slave_arb: N_MST must be 2..64");
   end
   if (N_FIXED < 0 || N_FIXED >= N_MST) begin : g_bad_fix
      $error("tiered_slave_arb: N_FIXED must leave at least one round-robin master");
   end

   localparam logic [N_MST-1:0] FIX_MASK = N_MST'(low_mask(N_FIXED));

   logic [IDX_W-1:0] own_q, last_rr_q, nxt_idx;
   logic             fix_found, rr_found, beat, rearb, grant_new, budget_last;
   logic [IDX_W-1:0] fix_idx, rr_idx;
   logic [WGT_W-1:0] nxt_weight;

   tarb_fixed_pick #(.N_MST(N_MST), .N_FIXED(N_FIXED)) i_fixed (
      .req_i   (req_i),
      .found_o (fix_found),
      .idx_o   (fix_idx)
   );

   tarb_rr_pick #(.N_MST(N_MST), .N_FIXED(N_FIXED)) i_rr (
      .req_i   (req_i),
      .last_i  (last_rr_q),
      .found_o (rr_found),
      .idx_o   (rr_idx)
   );

   // A transfer boundary of the current owner.
   assign beat = ready_i & xfer_i[own_q];

   // Arbitration point: owner idle, or completing a transfer that ends its
   // budget, belongs to the fixed tier, or yields to a fixed-tier request.
   assign rearb = ready_i & ~lock_i[own_q] &
                  (~req_i[own_q] |
                   (beat & (FIX_MASK[own_q] | fix_found | budget_last)));

   assign grant_new = rearb & (fix_found | rr_found);
   assign nxt_idx   = fix_found ? fix_idx : rr_idx;
   assign nxt_weight = weight_i[nxt_idx*WGT_W +: WGT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q     <= '0;
         last_rr_q <= IDX_W'(N_MST - 1);
      end else if (grant_new) begin
         own_q <= nxt_idx;
         if (!fix_found) last_rr_q <= rr_idx;
      end
   end

   tarb_budget #(.WGT_W(WGT_W)) i_budget (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (grant_new),
      .weight_i (nxt_weight),
      .beat_i   (beat & ~grant_new),
      .last_o   (budget_last)
   );

   always_comb begin
      gnt_o = '0;
      gnt_o[own_q] = 1'b1;
   end
   assign gnt_idx_o = own_q;

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gnt_o) == 1 && gnt_o[gnt_idx_o]); // R1

   AST_FIXED_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_i && !lock_i[gnt_idx_o] && (|(req_i & FIX_MASK)) &&
       (!req_i[gnt_idx_o] || xfer_i[gnt_idx_o])) |=> FIX_MASK[gnt_idx_o]); // R2

   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i[gnt_idx_o] |=> $stable(gnt_idx_o)); // R7

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_i |=> $stable(gnt_idx_o)); // R11

   AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i == '0) |=> $stable(gnt_idx_o)); // R9

   AST_RELEASE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_i && !req_i[gnt_idx_o] && !lock_i[gnt_idx_o] && (req_i != '0))
      |=> !$stable(gnt_idx_o)); // R8

endmodule

// File: tb/test_tiered_slave_arb.sv
`timescale 1ns/1ps
module test_tiered_slave_arb;

   localparam int N  = 5;
   localparam int NF = 2;
   localparam int WW = 3;
   localparam int IW = $clog2(N);

   logic            clk = 1'b0;
   logic            rst_n;
   logic            ready;
   logic [N-1:0]    req, lock, xfer;
   logic [N*WW-1:0] wgt;
   logic [N-1:0]    gnt;
   logic [IW-1:0]   gidx;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   // Every granted, requesting master completes a transfer whenever ready.
   assign xfer = gnt & req & {N{ready}};

   tiered_slave_arb #(.N_MST(N), .N_FIXED(NF), .WGT_W(WW)) i_tiered_slave_arb (
      .clk(clk), .rst_n(rst_n), .ready_i(ready), .req_i(req), .lock_i(lock),
      .xfer_i(xfer), .weight_i(wgt), .gnt_o(gnt), .gnt_idx_o(gidx)
   );

   task automatic check(input int exp, input string tag);
      n_cmp++;
      if (int'(gidx) != exp || gnt != N'(1 << exp)) begin
         n_bad++;
         $display("FAIL %s: idx=%0d gnt=%b expected idx=%0d gnt=%b",
                  tag, gidx, gnt, exp, N'(1 << exp));
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req = '0; lock = '0; ready = 1'b1;
      repeat (2) @(negedge clk);
      check(0, "R1 reset park");
      rst_n = 1'b1;
   endtask

   task automatic set_w(input int m, input int v);
      wgt[m*WW +: WW] = WW'(v);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
   end

   initial begin
      wgt = '0;
      // R4 R5 R6: exhaustive weight sweep of masters 2 and 3.
      for (int wa = 0; wa < 8; wa++) begin
         for (int wb = 0; wb < 8; wb++) begin
            int a, b, p;
            a = (wa == 0) ? 1 : wa;
            b = (wb == 0) ? 1 : wb;
            p = a + b;
            set_w(2, wa); set_w(3, wb);
            do_reset();
            req = 5'b01100;
            for (int c = 0; c < 2 * p; c++) begin
               @(negedge clk);
               check(((c % p) < a) ? 2 : 3, "R4/R5/R6 group sweep");
            end
         end
      end

      // R7: lock holds grant past a one-transfer budget.
      set_w(2, 1); set_w(3, 1);
      do_reset();
      req = 5'b01100; lock = 5'b00100;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         check(2, "R7 lock hold");
      end
      lock = '0;
      @(negedge clk); check(3, "R7 after lock release");

      // R2 R3 R6: pre-emption, fixed order, rotation resume.
      set_w(2, 7); set_w(3, 7);
      do_reset();
      req = 5'b01100;
      @(negedge clk); check(2, "R6 first rr grant");
      req = 5'b01110;
      @(negedge clk); check(1, "R2 fixed preempts rr");
      req = 5'b01111;
      @(negedge clk); check(0, "R3 lower fixed index wins");
      req = 5'b01100;
      @(negedge clk); check(3, "R6 rotation after last rr");

      // R11: stall keeps the grant.
      ready = 1'b0; req = 5'b01101;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk); check(3, "R11 stall hold");
      end
      ready = 1'b1;
      @(negedge clk); check(0, "R2 preempt after stall");

      // R9: parking.
      req = '0;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk); check(0, "R9 park");
      end

      // R8: release moves the grant.
      req = 5'b01100;
      @(negedge clk); check(2, "R6 wrap to first rr");
      req = 5'b01000;
      @(negedge clk); check(3, "R8 owner drops request");

      // R10: weight change mid-grant.
      set_w(2, 4); set_w(3, 2);
      do_reset();
      req = 5'b01100;
      @(negedge clk); check(2, "R10 start");
      set_w(2, 1);
      begin
         int exp_seq[9] = '{2, 2, 2, 3, 3, 2, 3, 3, 2};
         for (int c = 0; c < 9; c++) begin
            @(negedge clk); check(exp_seq[c], "R10 weight update");
         end
      end

      finish_run();
   end

endmodule